// File: doc/BRIEF.md
# Serial Audio Output Clock and Data Generator

This block drives a three-wire serial audio output as the clock master. From a master clock running at 512 times the frame rate it derives the bit clock, the word (channel) clock and the serial data line. A stereo sample pair arrives in parallel with a one-cycle load strobe. The block holds the pair and starts sending it at the next frame boundary. If no new pair has arrived by then, the previous pair is sent again.

Three alignments of the word inside a channel slot are supported: MSB-first, MSB delayed by one bit, and LSB-last. Each works with 16, 20 or 24-bit words. The bit clock runs at 64 or 32 times the frame rate. At 32 times, a packed 16-bit layout fills every bit slot.

An external sync line can realign the frame. A falling edge on it restarts the output counters in the middle of a frame. The pair that was cut short is then reported as invalid. A bypass control makes the block ignore the sync line.

Top module: `serial_audio_out`

## Requirements
- R1: While `rst` is high, `bclk`, `lrclk`, `sdata` and `pair_invalid` are all low. After `rst` falls, the first frame opens with the left channel, which lasts 256 master-clock cycles.
- R2: With `bclk_32x` low, `bclk` has a period of 8 master-clock cycles and is high for 4 of them. Each channel half carries 32 bit slots.
- R3: With `bclk_32x` high, `bclk` has a period of 16 master-clock cycles and is high for 8 of them. Each channel half carries 16 bit slots.
- R4: `lrclk` changes level every 256 master-clock cycles. It is high during the left channel, except with `fmt_sel`=1 at the 64x ratio, where it is low during the left channel.
- R5: `sdata` changes only while `bclk` is low, so it is stable at every rising `bclk` edge.
- R6: With `fmt_sel` set to 0 or 3 at the 64x ratio, the word MSB is in the first bit slot after an `lrclk` change and the word is sent MSB first. All other slots carry zero.
- R7: With `fmt_sel`=1 at the 64x ratio, the MSB is in the second bit slot of the channel. The first slot and all slots after the LSB carry zero.
- R8: With `fmt_sel`=2 at the 64x ratio, the LSB is in the last bit slot before the next `lrclk` change. All slots before the MSB carry zero.
- R9: `len_sel` picks the word length: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 give 24 bits. A word sits right-aligned in its 24-bit input, with its MSB at bit (length-1).
- R10: At the 32x ratio the output is packed regardless of `fmt_sel`. The 16 most significant bits of the selected word fill all 16 slots, MSB right after the `lrclk` change and LSB right before the next one, with `lrclk` high for left.
- R11: A pair loaded with `pair_load` is taken into use only at the next frame boundary. A frame already in progress keeps the old pair, and a frame with no new load repeats the last pair.
- R12: A falling edge on `frame_sync` moves the counters to the right-channel start. At the 64x ratio, `lrclk` changes two master-clock cycles after `frame_sync` is first sampled low. At the 32x ratio, the change comes 16 cycles later than that. The next channel change then follows 256 cycles on. `pair_invalid` goes high the cycle after the edge and stays high until the frame ends.
- R13: While `sync_off` is high, `frame_sync` edges leave the frame timing unchanged and `pair_invalid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 512 cycles per frame |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Realignment input, acts on its falling edge |
| sync_off | input | 1 | When high, realignment is ignored |
| bclk_32x | input | 1 | 0: bit clock at 64x frame rate, 1: 32x packed |
| fmt_sel | input | 2 | 0/3 MSB-first, 1 MSB delayed one bit, 2 LSB-last |
| len_sel | input | 2 | Word length: 0=16, 1=20, 2/3=24 bits |
| pair_load | input | 1 | One-cycle strobe capturing the sample pair |
| left_word | input | 24 | Left sample, right-aligned |
| right_word | input | 24 | Right sample, right-aligned |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel (word) clock |
| sdata | output | 1 | Serial data, changes on falling bit clock |
| pair_invalid | output | 1 | High while the frame cut by a sync edge runs out |

## Verification
The bench builds the block with its default 16-cycle realignment lag at the 32x ratio. At that lag, both the immediate channel change at 64x and the delayed change at 32x fall on exact master-clock counts that the bench can check. Every alignment code and every word-length code is used at both ratios, so the first slot, the last slot and the zero padding of each layout are checked. Random sample words set the bits at every position.

// File: rtl/sao_pkg.sv
`timescale 1ns/1ps
package sao_pkg;
  // master clock cycles per frame is 2**CNT_W
  localparam int unsigned CNT_W    = 9;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned SLOTS_64 = 32;  // bit slots per channel at 64x
  localparam int unsigned SLOTS_32 = 16;  // bit slots per channel at 32x

  typedef enum logic [1:0] {
    ALIGN_MSB     = 2'd0,
    ALIGN_DELAYED = 2'd1,
    ALIGN_LSB     = 2'd2,
    ALIGN_MSB_ALT = 2'd3
  } align_e;

  typedef struct packed {
    align_e     align;
    logic [1:0] wsel;
    logic       narrow;  // 32x packed ratio
  } cfg_t;

  // length of the selected word in bits
  function automatic logic [4:0] word_bits(input logic [1:0] wsel);
    unique case (wsel)
      2'd0:    word_bits = 5'd16;
      2'd1:    word_bits = 5'd20;
      default: word_bits = 5'd24;
    endcase
  endfunction

  // bits actually put on the line per channel
  function automatic logic [4:0] sent_bits(input cfg_t c);
    sent_bits = c.narrow ? 5'd16 : word_bits(c.wsel);
  endfunction

  // zero slots ahead of the MSB within a channel
  function automatic logic [5:0] lead_slots(input cfg_t c);
    if (c.narrow) begin
      lead_slots = 6'd0;
    end else begin
      unique case (c.align)
        ALIGN_DELAYED: lead_slots = 6'd1;
        ALIGN_LSB:     lead_slots = 6'(SLOTS_64) - {1'b0, word_bits(c.wsel)};
        default:       lead_slots = 6'd0;
      endcase
    end
  endfunction

  // line value for a slot position within a channel
  function automatic logic pick_bit(input cfg_t c, input logic [4:0] pos,
                                    input logic [SAMPLE_W-1:0] w);
    logic [5:0] lead;
    logic [5:0] k;
    logic [4:0] wb;
    lead = lead_slots(c);
    wb   = word_bits(c.wsel);
    k    = {1'b0, pos} - lead;
    if (({1'b0, pos} >= lead) && (k < {1'b0, sent_bits(c)}))
      pick_bit = w[wb - 5'd1 - k[4:0]];
    else
      pick_bit = 1'b0;
  endfunction
endpackage

// File: rtl/sao_frame_ctr.sv
`timescale 1ns/1ps
module sao_frame_ctr
  import sao_pkg::*;
#(
  parameter int unsigned LAG_NARROW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             bypass_i,
  input  logic             narrow_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             sync_hit_o,
  output logic             pair_bad_o
);
  localparam int unsigned HALF_CNT = 2 ** (CNT_W - 1);
  localparam logic [CNT_W-1:0] LOAD_WIDE   = CNT_W'(HALF_CNT);
  localparam logic [CNT_W-1:0] LOAD_NARROW = CNT_W'(HALF_CNT - LAG_NARROW);

  logic sync_q;

  assign sync_hit_o = sync_q & ~sync_i & ~bypass_i;
  assign wrap_o     = (cnt_o == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o      <= '0;
      sync_q     <= 1'b0;
      pair_bad_o <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (sync_hit_o)
        cnt_o <= narrow_i ? LOAD_NARROW : LOAD_WIDE;
      else
        cnt_o <= cnt_o + CNT_W'(1);
      if (sync_hit_o)
        pair_bad_o <= 1'b1;
      else if (wrap_o)
        pair_bad_o <= 1'b0;
    end
  end

  // R12: flag persists until the frame ends
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (pair_bad_o && !wrap_o && !sync_hit_o) |=> pair_bad_o);
  // R12: flag drops at the frame boundary
  p_flag_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !sync_hit_o) |=> !pair_bad_o);
  // R13: with bypass the counter keeps running through a sync edge
  p_bypass_run_r13: assert property (@(posedge clk) disable iff (rst)
    (bypass_i && sync_q && !sync_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/sao_pair_hold.sv
`timescale 1ns/1ps
module sao_pair_hold
  import sao_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                frame_start_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic [SAMPLE_W-1:0] left_q, right_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      if (load_i) begin
        left_q  <= left_i;
        right_q <= right_i;
      end
      if (frame_start_i) begin
        left_o  <= load_i ? left_i  : left_q;
        right_o <= load_i ? right_i : right_q;
      end
    end
  end

  // R11: the pair on the line only changes at a frame boundary
  p_pair_steady_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_start_i |=> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/sao_shifter.sv
`timescale 1ns/1ps
module sao_shifter
  import sao_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cnt_i,
  input  cfg_t                cfg_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o
);
  logic                half;
  logic [4:0]          pos;
  logic                bclk_n, lr_n, bit_n;
  logic [SAMPLE_W-1:0] word;
  cfg_t                cfg_prev;
  logic                cfg_moved_q;

  always_comb begin
    half   = cnt_i[CNT_W-1];
    pos    = cfg_i.narrow ? {1'b0, cnt_i[CNT_W-2:4]} : cnt_i[CNT_W-2:3];
    bclk_n = cfg_i.narrow ? cnt_i[3] : cnt_i[2];
    lr_n   = (!cfg_i.narrow && cfg_i.align == ALIGN_DELAYED) ? half : ~half;
    word   = half ? right_i : left_i;
    bit_n  = pick_bit(cfg_i, pos, word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_o      <= 1'b0;
      lrclk_o     <= 1'b0;
      sdata_o     <= 1'b0;
      cfg_prev    <= '0;
      cfg_moved_q <= 1'b0;
    end else begin
      bclk_o      <= bclk_n;
      lrclk_o     <= lr_n;
      sdata_o     <= bit_n;
      cfg_prev    <= cfg_i;
      cfg_moved_q <= (cfg_i != cfg_prev);
    end
  end

  // R5: data moves only while the bit clock is low
  p_data_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    ($changed(sdata_o) && !cfg_moved_q) |-> !bclk_o);
endmodule

// File: rtl/serial_audio_out.sv
`timescale 1ns/1ps
module serial_audio_out
  import sao_pkg::*;
#(
  parameter int unsigned SYNC_LAG_32X = 16
) (
  input  logic                mclk,
  input  logic                rst,
  input  logic                frame_sync,
  input  logic                sync_off,
  input  logic                bclk_32x,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          len_sel,
  input  logic                pair_load,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                pair_invalid
);
  cfg_t                cfg;
  logic [CNT_W-1:0]    cnt;
  logic                wrap, sync_hit, frame_start;
  logic [SAMPLE_W-1:0] cur_l, cur_r;

  assign cfg         = '{align: align_e'(fmt_sel), wsel: len_sel, narrow: bclk_32x};
  assign frame_start = wrap & ~sync_hit;

  sao_frame_ctr #(.LAG_NARROW(SYNC_LAG_32X)) u_ctr (
    .clk(mclk), .rst(rst), .sync_i(frame_sync), .bypass_i(sync_off),
    .narrow_i(bclk_32x), .cnt_o(cnt), .wrap_o(wrap),
    .sync_hit_o(sync_hit), .pair_bad_o(pair_invalid)
  );

  sao_pair_hold u_hold (
    .clk(mclk), .rst(rst), .load_i(pair_load), .left_i(left_word),
    .right_i(right_word), .frame_start_i(frame_start),
    .left_o(cur_l), .right_o(cur_r)
  );

  sao_shifter u_shift (
    .clk(mclk), .rst(rst), .cnt_i(cnt), .cfg_i(cfg), .left_i(cur_l),
    .right_i(cur_r), .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata)
  );

  // R12: at 64x the channel clock drops two cycles after the sync edge
  p_lr_after_sync_r12: assert property (@(posedge mclk) disable iff (rst)
    (sync_hit && !cfg.narrow && cfg.align != ALIGN_DELAYED)
      |=> ##1 (!lrclk || ($past(cfg) != $past(cfg, 2))));
  // R12: a sync edge raises the invalid flag
  p_flag_set_r12: assert property (@(posedge mclk) disable iff (rst)
    sync_hit |=> pair_invalid);
endmodule

// File: tb/serial_audio_out_test.sv
`timescale 1ns/1ps
module serial_audio_out_test;
  logic mclk = 1'b0, rst = 1'b1, sync = 1'b1, byp = 1'b0, nar = 1'b0;
  logic [1:0] fmt = 2'd0, wsel = 2'd2;
  logic load = 1'b0;
  logic [23:0] lin = '0, rin = '0;
  wire bclk, lrclk, sdata, bad;

  serial_audio_out uut (
    .mclk(mclk), .rst(rst), .frame_sync(sync), .sync_off(byp), .bclk_32x(nar),
    .fmt_sel(fmt), .len_sel(wsel), .pair_load(load), .left_word(lin),
    .right_word(rin), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .pair_invalid(bad)
  );

  always #5 mclk = ~mclk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit done = 0;
  always @(posedge mclk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int wlen(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : 24;
  endfunction
  function automatic int slots_now();
    return nar ? 16 : 32;
  endfunction
  function automatic bit left_level();
    return (fmt == 2'd1 && !nar) ? 1'b0 : 1'b1;
  endfunction
  // expected line bits of one channel, first slot in the MSB of a 32-bit image
  function automatic longint exp_image(input logic [23:0] w);
    int n = wlen(wsel);
    int s = slots_now();
    int start;
    longint img = 0;
    longint top;
    if (nar) begin
      top = longint'(w >> (n - 16)) & 64'hFFFF;
      return top;
    end
    start = (fmt == 2'd1) ? 1 : (fmt == 2'd2) ? (s - n) : 0;
    top = longint'(w) & ((64'd1 << n) - 1);
    img = top << (s - start - n);
    return img;
  endfunction
  function automatic string fmt_req();
    if (nar) return "R10";
    if (fmt == 2'd1) return "R7";
    if (fmt == 2'd2) return "R8";
    return "R6";
  endfunction

  logic chk_en = 0;
  logic [23:0] exp_l = '0, exp_r = '0;
  bit pb = 0, plr = 0, psd = 0;
  longint last_rise = -1, last_lr = -1;
  bit seg_act = 0, seg_en = 0, seg_lr = 0;
  int seg_n = 0;
  longint seg_img = 0;
  logic [23:0] seg_w;

  task automatic finish_seg();
    chk(seg_n == slots_now(), nar ? "R3" : "R2", "slots per channel", seg_n, slots_now());
    chk(seg_img == exp_image(seg_w), fmt_req(), (wsel == 2'd0) ? "word R9 len16" :
        (wsel == 2'd1) ? "word R9 len20" : "word R9 len24", seg_img, exp_image(seg_w));
  endtask

  always @(negedge mclk) begin
    if (!chk_en) begin
      last_rise = -1; last_lr = -1; seg_act = 0;
    end else begin
      if (sdata !== psd) chk(bclk == 1'b0, "R5", "bclk at data change", bclk, 0);
      if (lrclk !== plr) begin
        if (last_lr >= 0) chk(cyc - last_lr == 256, "R4", "half frame", cyc - last_lr, 256);
        last_lr = cyc;
      end
      if (bclk && !pb) begin
        if (last_rise >= 0)
          chk(cyc - last_rise == (nar ? 16 : 8), nar ? "R3" : "R2", "bclk period",
              cyc - last_rise, nar ? 16 : 8);
        last_rise = cyc;
        if (!seg_act || lrclk != seg_lr) begin
          if (seg_act && seg_en) finish_seg();
          seg_en  = seg_act;
          seg_act = 1;
          seg_lr  = lrclk;
          seg_n   = 0;
          seg_img = 0;
          seg_w   = (lrclk == left_level()) ? exp_l : exp_r;
        end
        seg_img = (seg_img << 1) | longint'(sdata);
        seg_n++;
      end
      if (!bclk && pb && last_rise >= 0)
        chk(cyc - last_rise == (nar ? 8 : 4), nar ? "R3" : "R2", "bclk high time",
            cyc - last_rise, nar ? 8 : 4);
    end
    pb = bclk; plr = lrclk; psd = sdata;
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge mclk);
  endtask
  task automatic wait_lr(input bit lvl);
    @(negedge mclk);
    while (lrclk == lvl) @(negedge mclk);
    while (lrclk != lvl) @(negedge mclk);
  endtask
  task automatic load_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge mclk); lin = l; rin = r; load = 1;
    @(negedge mclk); load = 0;
  endtask
  task automatic run_cfg(input bit n, input logic [1:0] f, input logic [1:0] w,
                         input logic [23:0] l, input logic [23:0] r);
    chk_en = 0;
    @(negedge mclk); nar = n; fmt = f; wsel = w;
    load_pair(l, r);
    wait_neg(1100);
    exp_l = l; exp_r = r;
    chk_en = 1;
    wait_neg(1200);
    chk_en = 0;
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'd20517));
    wait_neg(6);
    chk(bclk == 0, "R1", "bclk in reset", bclk, 0);
    chk(lrclk == 0, "R1", "lrclk in reset", lrclk, 0);
    chk(sdata == 0, "R1", "sdata in reset", sdata, 0);
    chk(bad == 0, "R1", "invalid in reset", bad, 0);
    rst = 0;
    wait_neg(1);
    chk(lrclk == 1, "R1", "left first", lrclk, 1);
    wait_neg(255);
    chk(lrclk == 1, "R1", "left length end", lrclk, 1);
    wait_neg(1);
    chk(lrclk == 0, "R1", "right start", lrclk, 0);

    run_cfg(0, 2'd0, 2'd2, 24'h800001, 24'h5A3C96);
    run_cfg(0, 2'd3, 2'd0, 24'h00C003, 24'h00FFFE);
    run_cfg(0, 2'd1, 2'd2, 24'hC00003, 24'h123456);
    run_cfg(0, 2'd2, 2'd0, 24'h008001, 24'h00FFFF);
    run_cfg(0, 2'd2, 2'd1, 24'h080001, 24'h0A5A5A);
    run_cfg(0, 2'd2, 2'd3, 24'hFFFFFF, 24'h800000);
    run_cfg(1, 2'd0, 2'd2, 24'hABCDEF, 24'h8000FF);
    run_cfg(1, 2'd2, 2'd0, 24'h008001, 24'h00F00F);
    run_cfg(1, 2'd1, 2'd1, 24'h0FEDCB, 24'h08ABCD);

    // R11: a load mid-frame waits for the next frame boundary
    run_cfg(0, 2'd0, 2'd2, 24'h111111, 24'h222222);
    exp_l = 24'h111111; exp_r = 24'h222222;
    chk_en = 1;
    wait_lr(1'b1); wait_neg(20);
    load_pair(24'hE0E0E0, 24'h0F0F0F);
    wait_lr(1'b0); wait_neg(20);
    exp_l = 24'hE0E0E0; exp_r = 24'h0F0F0F;
    wait_neg(1100);
    chk_en = 0;

    // R12: sync at 64x
    wait_lr(1'b1); wait_neg(40);
    sync = 0;
    wait_neg(1);
    chk(lrclk == 1, "R12", "lrclk one cycle after sync", lrclk, 1);
    chk(bad == 1, "R12", "invalid set", bad, 1);
    wait_neg(1);
    chk(lrclk == 0, "R12", "lrclk two cycles after sync", lrclk, 0);
    t = 0;
    while (lrclk == 0 && t < 600) begin @(negedge mclk); t++; end
    chk(t == 256, "R12", "half frame after sync", t, 256);
    chk(bad == 0, "R12", "invalid cleared at frame end", bad, 0);
    sync = 1;
    exp_l = 24'hE0E0E0; exp_r = 24'h0F0F0F;
    wait_neg(600);
    chk_en = 1; wait_neg(1100); chk_en = 0;

    // R12: sync at 32x
    @(negedge mclk); nar = 1;
    wait_neg(1100);
    wait_lr(1'b1); wait_neg(40);
    sync = 0;
    wait_neg(1);
    chk(bad == 1, "R12", "invalid set 32x", bad, 1);
    wait_neg(16);
    chk(lrclk == 1, "R12", "lrclk before lag 32x", lrclk, 1);
    wait_neg(1);
    chk(lrclk == 0, "R12", "lrclk after lag 32x", lrclk, 0);
    wait_neg(180);
    chk(bad == 1, "R12", "invalid held 32x", bad, 1);
    sync = 1;

    // R13: bypass ignores sync
    @(negedge mclk); nar = 0; byp = 1;
    wait_neg(1100);
    wait_lr(1'b1);
    t = 0;
    while (lrclk == 1 && t < 600) begin
      @(negedge mclk); t++;
      if (t == 40) sync = 0;
    end
    chk(t == 256, "R13", "left length with bypass", t, 256);
    chk(bad == 0, "R13", "invalid stays low", bad, 0);
    sync = 1;
    wait_neg(10);
    byp = 0;

    for (int i = 0; i < 10; i++)
      run_cfg(1'($urandom % 2), 2'($urandom % 4), 2'($urandom % 4),
              24'($urandom), 24'($urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule